// File: doc/BRIEF.md
# Self-Clearing Single-Port RAM

This block is a single-port synchronous memory, 512 words of 8 bits by default. It has a registered read port. The storage array has no reset path, so it can map onto on-chip block memory. A small controller zeroes the contents one word per clock instead. Each time reset is applied, the controller takes over the memory address and write path and writes zero to every location in ascending order. During that walk it raises a busy flag. When the walk ends it gives a single-cycle completion pulse.

Once the clear has finished, the user side owns the memory. A cycle with write enable high stores the write data and leaves the read register unchanged. A cycle with write enable low loads the read register from the presented address. The data therefore appears one clock after the address. While the clear runs, user writes are discarded and the read output stays at zero. If reset arrives again in the middle of a clear, the walk starts over from address zero.

The controller has two states:
- `ST_CLEAR` is the walking state.
- `ST_IDLE` is the state in which the user owns the memory.

It has four transitions:
- RESET: any state goes to `ST_CLEAR` with the pointer at 0.
- STEP: `ST_CLEAR` stays in `ST_CLEAR` and the pointer advances by one.
- FINISH: `ST_CLEAR` goes to `ST_IDLE` after the top address is written, and the completion pulse fires.
- HOLD: `ST_IDLE` stays in `ST_IDLE`.

Top module: `zeroing_ram`

## Requirements
- R1: When not busy and `we` is low at a rising edge, `rdata` shows the word stored at `addr` from that edge onward, which is one clock after the address was presented.
- R2: While `rst` is high, and in the first cycle after it falls, `busy` is 1, `done` is 0 and `rdata` is 0.
- R3: The clear writes zero to addresses 0 through 511 in ascending order, one per clock. Afterwards every location reads back as 0x00, whatever it held before.
- R4: When not busy, a rising edge with `we` high stores `wdata` at `addr` and leaves `rdata` at its previous value.
- R5: While `busy` is 1, a high `we` is dropped and the addressed location is not changed. `rdata` stays at 0x00 for the whole clear.
- R6: After `rst` falls, `busy` stays high for exactly 512 clock cycles and then goes low.
- R7: `done` is high for exactly one cycle, which is the first cycle with `busy` low after a clear. It is low otherwise.
- R8: Asserting `rst` during a clear restarts it. After release, `busy` again lasts 512 cycles, and all locations read 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; starts a clear |
| we | input | 1 | Write enable (user side) |
| addr | input | 9 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while the clear is in progress |
| done | output | 1 | One-cycle pulse when the clear completes |

## Verification
The assertions check these behaviours on every cycle:
- `rdata` is zero throughout a clear.
- `rdata` is unchanged across user write cycles.
- The clear pointer advances by exactly one per busy cycle.
- A checker counter shows that each busy period lasts 512 cycles.
- `done` pulses once, exactly when `busy` falls.

Some behaviours depend on the memory contents, and only the bench scenarios can show them. These are that every location really reads zero after a clear, that written data reads back one clock later, that writes attempted during a clear never land, and that a reset in mid-clear restarts the walk.

// File: rtl/zr_pkg.sv
package zr_pkg;

    // Controller states: walking the array, or handing it to the user.
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_IDLE  = 1'b1
    } zr_state_t;

endpackage

// File: rtl/zr_clear_fsm.sv
module zr_clear_fsm
    import zr_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] clr_addr
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    zr_state_t     state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic          finish;

    // Next-state logic (transitions STEP, FINISH, HOLD; RESET is in the register)
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                if (ptr_q == LAST_ADDR) begin
                    state_d = ST_IDLE;          // FINISH
                    ptr_d   = '0;
                    finish  = 1'b1;
                end else begin
                    ptr_d   = ptr_q + 1'b1;     // STEP
                end
            end
            ST_IDLE: begin
                state_d = ST_IDLE;              // HOLD
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;                // RESET
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else begin
            done <= finish;
        end
    end

    assign busy     = (state_q == ST_CLEAR);
    assign clr_addr = ptr_q;

endmodule

// File: rtl/zr_port_mux.sv
module zr_port_mux #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             busy,
    input  logic [AW-1:0]    clr_addr,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_din,
    output logic             rd_en
);

    // The controller owns the single port while clearing; user requests are dropped.
    always_comb begin
        if (busy) begin
            mem_we   = 1'b1;
            mem_addr = clr_addr;
            mem_din  = '0;
            rd_en    = 1'b0;
        end else begin
            mem_we   = we;
            mem_addr = addr;
            mem_din  = wdata;
            rd_en    = ~we;
        end
    end

endmodule

// File: rtl/zr_array.sv
module zr_array #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout
);

    // Storage with no reset, so it can map onto block memory.
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= din;
        end
    end

    // Registered read; only the output register is reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_en) begin
            dout <= mem[addr];
        end
    end

endmodule

// File: rtl/zeroing_ram.sv
module zeroing_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             busy,
    output logic             done
);

    logic [AW-1:0]    clr_addr;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [WIDTH-1:0] mem_din;
    logic             rd_en;

    zr_clear_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .done     (done),
        .clr_addr (clr_addr)
    );

    zr_port_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mux (
        .busy     (busy),
        .clr_addr (clr_addr),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_din  (mem_din),
        .rd_en    (rd_en)
    );

    zr_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr),
        .din   (mem_din),
        .rd_en (rd_en),
        .dout  (rdata)
    );

endmodule

// File: rtl/zr_checker.sv
module zr_checker #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             we,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] rdata,
    input logic [AW-1:0]    clr_addr
);

    logic [AW:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 1'b1;
        end
    end

    // R5: read output stays zero while clearing
    a_r5_rdata_zero_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rdata == '0));

    // R4: a user write leaves the read register untouched
    a_r4_write_holds_rdata: assert property (@(posedge clk) disable iff (rst)
        (!busy && we) |=> $stable(rdata));

    // R3: clear pointer steps by one each busy cycle
    a_r3_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> (clr_addr == $past(clr_addr) + 1'b1));

    // R6: busy period lasts exactly DEPTH cycles
    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == (AW+1)'(DEPTH)));

    // R7: done coincides with the fall of busy and lasts one cycle
    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind zeroing_ram zr_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .clr_addr (clr_addr)
);

// File: tb/tb_zeroing_ram.sv
`timescale 1ns/1ps
module tb_zeroing_ram;

    logic       clk = 1'b0;
    logic       rst;
    logic       we;
    logic [8:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    zeroing_ram dut (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done)
    );

    // {we, addr[8:0], wdata[7:0], expected rdata one clock later}
    localparam logic [25:0] VEC [10] = '{
        {1'b1, 9'h005, 8'hA5, 8'h00},   // R4 write, read reg holds
        {1'b1, 9'h1FF, 8'h3C, 8'h00},   // R4 write top address
        {1'b0, 9'h005, 8'h00, 8'hA5},   // R1 read back
        {1'b0, 9'h1FF, 8'h00, 8'h3C},   // R1 read back top
        {1'b1, 9'h000, 8'h77, 8'h3C},   // R4 hold previous value
        {1'b0, 9'h000, 8'h00, 8'h77},   // R1
        {1'b0, 9'h006, 8'h00, 8'h00},   // R3 untouched location cleared
        {1'b0, 9'h005, 8'h00, 8'hA5},   // R1
        {1'b1, 9'h006, 8'hFF, 8'hA5},   // R4 hold
        {1'b0, 9'h006, 8'h00, 8'hFF}    // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    // Counts negedges with busy high, starting at the current negedge.
    // When inject is set, drives a write to address 7 for the first 500 cycles.
    task automatic count_busy(input bit inject, output int n);
        n = 0;
        if (inject) begin
            we = 1'b1; addr = 9'h007; wdata = 8'hEE;
        end
        while (busy === 1'b1 && n < 2000) begin
            if (n % 64 == 0) chk("R5 rdata zero while busy", rdata, 0);
            n++;
            if (inject && n == 500) we = 1'b0;
            @(negedge clk);
        end
        we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R2 busy in reset", busy, 1);
        chk("R2 done in reset", done, 0);
        chk("R2 rdata in reset", rdata, 0);

        rst = 1'b0;
        chk("R2 busy after release", busy, 1);
        chk("R2 rdata after release", rdata, 0);
        count_busy(1'b1, n);
        chk("R6 busy length", n, 512);
        chk("R7 done pulse", done, 1);
        @(negedge clk);
        chk("R7 done single", done, 0);
        chk("R6 busy stays low", busy, 0);

        // R5: write attempted during the clear must not have landed
        addr = 9'h007; we = 1'b0;
        @(negedge clk);
        chk("R5 dropped write", rdata, 0);

        // Vector table: R1/R4/R3
        for (int i = 0; i < 10; i++) begin
            we = VEC[i][25]; addr = VEC[i][24:16]; wdata = VEC[i][15:8];
            @(negedge clk);
            chk("R1/R4 vector", rdata, {24'h0, VEC[i][7:0]});
        end
        we = 1'b0;

        // Fill every location with nonzero data
        for (int a = 0; a < 512; a++) begin
            we = 1'b1; addr = 9'(a); wdata = 8'(a) ^ 8'h5A;
            if (wdata == 8'h00) wdata = 8'h01;
            @(negedge clk);
        end
        we = 1'b0;

        // R8: reset in the middle of a clear
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        chk("R8 busy mid-clear", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R2 done low on restart", done, 0);
        rst = 1'b0;
        count_busy(1'b0, n);
        chk("R8 busy length after restart", n, 512);
        chk("R7 done after restart", done, 1);

        // R3: every location reads zero
        for (int a = 0; a < 512; a++) begin
            addr = 9'(a); we = 1'b0;
            @(negedge clk);
            chk("R3 cleared location", rdata, 0);
        end

        // R1: memory usable again after the clear
        we = 1'b1; addr = 9'h123; wdata = 8'hC3;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        chk("R1 read after clear", rdata, 8'hC3);

        report();
    end

endmodule